// File: doc/BRIEF.md
# Global Shutter Readout Overhead Sequencer

This block paces the readout of a pipelined global-shutter pixel array that is exposed under external control. A high-to-low transition on the exposure input closes integration and opens a frame overhead interval, during which a pixel-sample strobe is held for a programmable number of sensor clocks. The block then walks a programmed band of rows. Each row begins with a row overhead interval, followed by a scan of 32-pixel kernels that starts at a programmable kernel and runs to the last kernel of the row. After the final row the block either returns to idle or starts the next frame immediately if an exposure edge was held pending.

All durations are expressed in sensor clocks. One sensor clock is four master clocks, and the block runs on the master clock. The frame overhead lasts 4N+2 sensor clocks and the row overhead lasts N+2 sensor clocks, where N is the programmed field value. Each kernel occupies one sensor clock. Configuration values are written through a simple write port, and writes are accepted only while the sequencer is held in its own active-low reset. The programmed timing therefore never changes part-way through a frame.

Top module: `gs_readout_seq`

## Requirements
- R1: With `rst` high at a clock edge (synchronous), all strobes and `overrun_o` read 0 and `row_o` and `kernel_o` read 0 afterwards. Configuration returns to these defaults: first row 0, last row 1709, row-overhead field 7, frame-overhead field 40, sample field 4 and column-start field 0.
- R2: While idle and running, an exposure edge starts the frame overhead. An exposure edge is `exposure_i` sampled 1 at one clock edge and 0 at the next. `fot_o` rises in the cycle after that edge and stays high for exactly (4·F+2)·4 cycles, where F is the 8-bit frame-overhead field.
- R3: Every row begins with `rot_o` high for exactly (N+2)·4 cycles. N is bits [4:0] of the row-overhead write, and bits above bit 4 are ignored.
- R4: `sample_o` is high during the first min(4·S, frame-overhead length) cycles of each frame overhead and low at all other times. S is the 8-bit sample field, and S=0 keeps `sample_o` low.
- R5: After each row overhead, `read_o` is high while `kernel_o` counts up by one every 4 cycles. The count starts at min(2·X, 52) and ends at kernel 52, which is `NUM_KERNELS`-1. X is the 5-bit column-start field.
- R6: `row_o` takes the first-row value when the first row overhead begins, and it increments at each later row overhead. The frame ends after the row whose number is at or above the last-row value, so a first row above the last row reads exactly one row. Afterwards all strobes are low, and `row_o` and `kernel_o` hold their final values.
- R7: An exposure edge during frame overhead is ignored and sets `overrun_o`. `overrun_o` stays set until `rst` or `seq_rst_n` low.
- R8: An exposure edge during row overhead or kernel readout is held as one pending start. The next frame overhead then begins in the cycle right after the final kernel slot, with no idle cycle. A further edge while one is already pending is dropped and sets `overrun_o`.
- R9: With `seq_rst_n` low at a clock edge, the sequencer goes idle and clears the pending start, `overrun_o`, `row_o` and `kernel_o`. Configuration writes take effect only in that state and are ignored while `seq_rst_n` is high. The write addresses are 0 first row, 1 last row, 2 row overhead, 3 frame overhead, 4 sample and 5 column start, and addresses 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| seq_rst_n | input | 1 | Active-low sequencer hold; configuration may be written while low |
| exposure_i | input | 1 | Exposure control; a falling transition ends integration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 11 | Configuration write value |
| fot_o | output | 1 | High during frame overhead |
| rot_o | output | 1 | High during row overhead |
| sample_o | output | 1 | Pixel-sample strobe inside frame overhead |
| read_o | output | 1 | High while a kernel is being read |
| kernel_o | output | 6 | Index of the kernel being read |
| row_o | output | 11 | Current row number |
| overrun_o | output | 1 | Sticky flag for dropped exposure edges |

## Verification
On every cycle, the in-line assertions check the measured length of each frame and row overhead against the programmed fields. They also check that the sample strobe is present at the start of frame overhead, that kernel numbers only step by one, that rows stay at or above the first row, that overrun is set by dropped edges and held, and that configuration is frozen while running. The bench alone can show that a pending edge produces a back-to-back frame, and that the column-start clamp and the one-row band behave as required. It alone can show that writes made while running leave the timing untouched and that the reset defaults give the expected durations. The bench shows this by comparing every output against a behavioural model on each clock.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    localparam int NUM_ROWS     = 1710;
    localparam int NUM_KERNELS  = 53;
    localparam int SCLK_DIV     = 4;
    localparam int ROT_FIELD_W  = 5;
    localparam int FOT_FIELD_W  = 8;
    localparam int SMP_FIELD_W  = 8;
    localparam int COL_FIELD_W  = 5;

    localparam int ROW_W   = $clog2(NUM_ROWS);
    localparam int KER_W   = $clog2(NUM_KERNELS);
    localparam int CFG_DW  = (ROW_W > 8) ? ROW_W : 8;
    localparam int FOT_MAX = ((2**FOT_FIELD_W - 1) * 4 + 2) * SCLK_DIV;
    localparam int CNT_W   = $clog2(FOT_MAX + 1);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FOT  = 2'd1,
        PH_ROT  = 2'd2,
        PH_READ = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        CA_ROW_FIRST = 3'd0,
        CA_ROW_LAST  = 3'd1,
        CA_ROT       = 3'd2,
        CA_FOT       = 3'd3,
        CA_SAMPLE    = 3'd4,
        CA_COL       = 3'd5
    } cfg_addr_e;

    typedef struct packed {
        logic [ROW_W-1:0]       row_first;
        logic [ROW_W-1:0]       row_last;
        logic [ROT_FIELD_W-1:0] rot_n;
        logic [FOT_FIELD_W-1:0] fot_n;
        logic [SMP_FIELD_W-1:0] samp_n;
        logic [COL_FIELD_W-1:0] col_start;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{
        row_first: '0,
        row_last:  ROW_W'(NUM_ROWS - 1),
        rot_n:     ROT_FIELD_W'(7),
        fot_n:     FOT_FIELD_W'(40),
        samp_n:    SMP_FIELD_W'(4),
        col_start: '0
    };

    function automatic logic [CNT_W-1:0] fot_cycles(input logic [FOT_FIELD_W-1:0] n);
        return CNT_W'((int'(n) * 4 + 2) * SCLK_DIV);
    endfunction

    function automatic logic [CNT_W-1:0] rot_cycles(input logic [ROT_FIELD_W-1:0] n);
        return CNT_W'((int'(n) + 2) * SCLK_DIV);
    endfunction

    function automatic logic [CNT_W-1:0] samp_cycles(input logic [SMP_FIELD_W-1:0] n);
        return CNT_W'(int'(n) * SCLK_DIV);
    endfunction

    function automatic logic [KER_W-1:0] first_kernel(input logic [COL_FIELD_W-1:0] x);
        int k;
        k = 2 * int'(x);
        if (k > NUM_KERNELS - 1) k = NUM_KERNELS - 1;
        return KER_W'(k);
    endfunction

endpackage

// File: rtl/gsr_cfg.sv
module gsr_cfg
    import gsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_run,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [CFG_DW-1:0] wdata,
    output cfg_t              cfg
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_DEFAULT;
        end else if (we && !seq_run) begin
            case (addr)
                CA_ROW_FIRST: cfg_q.row_first <= wdata[ROW_W-1:0];
                CA_ROW_LAST:  cfg_q.row_last  <= wdata[ROW_W-1:0];
                CA_ROT:       cfg_q.rot_n     <= wdata[ROT_FIELD_W-1:0];
                CA_FOT:       cfg_q.fot_n     <= wdata[FOT_FIELD_W-1:0];
                CA_SAMPLE:    cfg_q.samp_n    <= wdata[SMP_FIELD_W-1:0];
                CA_COL:       cfg_q.col_start <= wdata[COL_FIELD_W-1:0];
                default:      cfg_q           <= cfg_q;
            endcase
        end
    end

    assign cfg = cfg_q;

    // R9: no configuration change while the sequencer runs
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        seq_run |=> $stable(cfg_q));

endmodule

// File: rtl/gsr_trigger.sv
module gsr_trigger
    import gsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic seq_run,
    input  logic exposure_i,
    input  logic in_fot,
    input  logic accept,
    output logic start_req,
    output logic overrun_o
);

    logic exp_q;
    logic pend_q;
    logic ovr_q;
    logic fall;

    always_comb begin
        fall      = exp_q && !exposure_i;
        start_req = seq_run && (fall || pend_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q  <= 1'b0;
            pend_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            exp_q <= exposure_i;
            if (!seq_run) begin
                pend_q <= 1'b0;
                ovr_q  <= 1'b0;
            end else begin
                if (fall && (in_fot || pend_q)) ovr_q <= 1'b1;
                if (accept)                     pend_q <= 1'b0;
                else if (fall && !in_fot)       pend_q <= 1'b1;
            end
        end
    end

    assign overrun_o = ovr_q;

    assert_fot_edge_overrun_R7: assert property (@(posedge clk) disable iff (rst)
        (seq_run && fall && in_fot) |=> overrun_o);

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && seq_run) |=> overrun_o);

    assert_second_pending_R8: assert property (@(posedge clk) disable iff (rst)
        (seq_run && fall && pend_q) |=> overrun_o);

endmodule

// File: rtl/gsr_core.sv
module gsr_core
    import gsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             seq_run,
    input  cfg_t             cfg,
    input  logic             start_req,
    output logic             accept,
    output logic             in_fot,
    output logic             fot_o,
    output logic             rot_o,
    output logic             sample_o,
    output logic             read_o,
    output logic [KER_W-1:0] kernel_o,
    output logic [ROW_W-1:0] row_o
);

    localparam logic [CNT_W-1:0] KSLOT_LAST = CNT_W'(SCLK_DIV - 1);
    localparam logic [KER_W-1:0] KER_LAST   = KER_W'(NUM_KERNELS - 1);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] samp_q;
    logic [ROW_W-1:0] row_q;
    logic [KER_W-1:0] ker_q;

    logic slot_end;
    logic last_kernel;
    logic last_row;
    logic frame_end;

    always_comb begin
        slot_end    = (cnt_q == '0);
        last_kernel = (ker_q == KER_LAST);
        last_row    = (row_q >= cfg.row_last);
        frame_end   = (ph_q == PH_READ) && slot_end && last_kernel && last_row;
        accept      = start_req && ((ph_q == PH_IDLE) || frame_end);
    end

    always_ff @(posedge clk) begin
        if (rst || !seq_run) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            samp_q <= '0;
            row_q  <= '0;
            ker_q  <= '0;
        end else if (accept) begin
            ph_q   <= PH_FOT;
            cnt_q  <= fot_cycles(cfg.fot_n) - 1'b1;
            samp_q <= samp_cycles(cfg.samp_n);
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    ph_q <= PH_IDLE;
                end
                PH_FOT: begin
                    if (samp_q != '0) samp_q <= samp_q - 1'b1;
                    if (slot_end) begin
                        ph_q  <= PH_ROT;
                        cnt_q <= rot_cycles(cfg.rot_n) - 1'b1;
                        row_q <= cfg.row_first;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_ROT: begin
                    if (slot_end) begin
                        ph_q  <= PH_READ;
                        cnt_q <= KSLOT_LAST;
                        ker_q <= first_kernel(cfg.col_start);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_READ: begin
                    if (slot_end) begin
                        if (last_kernel) begin
                            if (last_row) begin
                                ph_q <= PH_IDLE;
                            end else begin
                                ph_q  <= PH_ROT;
                                cnt_q <= rot_cycles(cfg.rot_n) - 1'b1;
                                row_q <= row_q + 1'b1;
                            end
                        end else begin
                            ker_q <= ker_q + 1'b1;
                            cnt_q <= KSLOT_LAST;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        in_fot   = (ph_q == PH_FOT);
        fot_o    = in_fot;
        rot_o    = (ph_q == PH_ROT);
        read_o   = (ph_q == PH_READ);
        sample_o = in_fot && (samp_q != '0);
        kernel_o = ker_q;
        row_o    = row_q;
    end

    // interval length monitors for the duration checks
    logic [CNT_W-1:0] fot_len_q;
    logic [CNT_W-1:0] rot_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fot_len_q <= '0;
            rot_len_q <= '0;
        end else begin
            fot_len_q <= fot_o ? fot_len_q + 1'b1 : '0;
            rot_len_q <= rot_o ? rot_len_q + 1'b1 : '0;
        end
    end

    assert_fot_length_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(fot_o) && $past(seq_run)) |-> (fot_len_q == fot_cycles(cfg.fot_n)));

    assert_rot_length_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(rot_o) && $past(seq_run)) |-> (rot_len_q == rot_cycles(cfg.rot_n)));

    assert_sample_at_start_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(fot_o) && (cfg.samp_n != '0)) |-> sample_o);

    assert_kernel_step_R5: assert property (@(posedge clk) disable iff (rst)
        (read_o && $past(read_o) && (kernel_o != $past(kernel_o)))
            |-> (kernel_o == $past(kernel_o) + 1'b1));

    assert_row_floor_R6: assert property (@(posedge clk) disable iff (rst)
        rot_o |-> (row_o >= cfg.row_first));

endmodule

// File: rtl/gs_readout_seq.sv
module gs_readout_seq
    import gsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_rst_n,
    input  logic              exposure_i,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              fot_o,
    output logic              rot_o,
    output logic              sample_o,
    output logic              read_o,
    output logic [KER_W-1:0]  kernel_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              overrun_o
);

    cfg_t cfg;
    logic start_req;
    logic accept;
    logic in_fot;

    gsr_cfg i_cfg (
        .clk     (clk),
        .rst     (rst),
        .seq_run (seq_rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .cfg     (cfg)
    );

    gsr_trigger i_trigger (
        .clk        (clk),
        .rst        (rst),
        .seq_run    (seq_rst_n),
        .exposure_i (exposure_i),
        .in_fot     (in_fot),
        .accept     (accept),
        .start_req  (start_req),
        .overrun_o  (overrun_o)
    );

    gsr_core i_core (
        .clk       (clk),
        .rst       (rst),
        .seq_run   (seq_rst_n),
        .cfg       (cfg),
        .start_req (start_req),
        .accept    (accept),
        .in_fot    (in_fot),
        .fot_o     (fot_o),
        .rot_o     (rot_o),
        .sample_o  (sample_o),
        .read_o    (read_o),
        .kernel_o  (kernel_o),
        .row_o     (row_o)
    );

endmodule

// File: tb/test_gs_readout_seq.sv
module test_gs_readout_seq;
    import gsr_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst = 1'b1;
    logic              seq_rst_n = 1'b0;
    logic              exposure_i = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [CFG_DW-1:0] cfg_wdata = '0;
    logic              fot_o, rot_o, sample_o, read_o, overrun_o;
    logic [KER_W-1:0]  kernel_o;
    logic [ROW_W-1:0]  row_o;

    gs_readout_seq i_gs_readout_seq (
        .clk(clk), .rst(rst), .seq_rst_n(seq_rst_n), .exposure_i(exposure_i),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .fot_o(fot_o), .rot_o(rot_o), .sample_o(sample_o), .read_o(read_o),
        .kernel_o(kernel_o), .row_o(row_o), .overrun_o(overrun_o)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    localparam int WD_LIMIT = 100000;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 frame overhead, 2 row overhead, 3 kernel read
    int  m_ph = 0, m_el = 0, m_row = 0, m_ker = 0;
    bit  m_pend = 0, m_ovr = 0, m_exp_prev = 0, m_live = 0;
    int  c_first = 0, c_last = NUM_ROWS - 1, c_rot = 7, c_fot = 40, c_samp = 4, c_col = 0;

    always @(posedge clk) begin
        int  old_ph, first_k;
        bit  fall, req, took, pend_old;
        if (rst) begin
            m_live = 1; m_ph = 0; m_el = 0; m_row = 0; m_ker = 0;
            m_pend = 0; m_ovr = 0; m_exp_prev = 0;
            c_first = 0; c_last = NUM_ROWS - 1; c_rot = 7; c_fot = 40; c_samp = 4; c_col = 0;
        end else begin
            fall = m_exp_prev && !exposure_i;
            m_exp_prev = exposure_i;
            if (!seq_rst_n) begin
                m_ph = 0; m_el = 0; m_row = 0; m_ker = 0; m_pend = 0; m_ovr = 0;
                if (cfg_we) begin
                    case (int'(cfg_addr))
                        0: c_first = int'(cfg_wdata);
                        1: c_last  = int'(cfg_wdata);
                        2: c_rot   = int'(cfg_wdata) % 32;
                        3: c_fot   = int'(cfg_wdata) % 256;
                        4: c_samp  = int'(cfg_wdata) % 256;
                        5: c_col   = int'(cfg_wdata) % 32;
                        default: ;
                    endcase
                end
            end else begin
                old_ph = m_ph; pend_old = m_pend;
                req = fall || m_pend; took = 0;
                first_k = (2 * c_col > NUM_KERNELS - 1) ? NUM_KERNELS - 1 : 2 * c_col;
                case (m_ph)
                    0: if (req) begin m_ph = 1; m_el = 0; took = 1; end
                    1: if (m_el + 1 == (4 * c_fot + 2) * 4) begin
                           m_ph = 2; m_el = 0; m_row = c_first;
                       end else m_el++;
                    2: if (m_el + 1 == (c_rot + 2) * 4) begin
                           m_ph = 3; m_el = 0; m_ker = first_k;
                       end else m_el++;
                    default: if (m_el + 1 == 4) begin
                           m_el = 0;
                           if (m_ker == NUM_KERNELS - 1) begin
                               if (m_row >= c_last) begin
                                   if (req) begin m_ph = 1; took = 1; end
                                   else m_ph = 0;
                               end else begin
                                   m_row++; m_ph = 2;
                               end
                           end else m_ker++;
                       end else m_el++;
                endcase
                if (fall && (old_ph == 1 || pend_old)) m_ovr = 1;
                if (took) m_pend = 0;
                else if (fall && old_ph != 1) m_pend = 1;
            end
        end
    end

    bit fot_seen = 0;
    int frames = 0;

    always @(negedge clk) begin
        if (m_live) begin
            chk("R2 R8", "fot_o", int'(fot_o), int'(m_ph == 1));
            chk("R3", "rot_o", int'(rot_o), int'(m_ph == 2));
            chk("R4", "sample_o", int'(sample_o), int'(m_ph == 1 && m_el < 4 * c_samp));
            chk("R5", "read_o", int'(read_o), int'(m_ph == 3));
            chk("R5", "kernel_o", int'(kernel_o), m_ker);
            chk("R6", "row_o", int'(row_o), m_row);
            chk("R7", "overrun_o", int'(overrun_o), int'(m_ovr));
        end
        if (fot_o && !fot_seen) frames++;
        fot_seen = fot_o;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wcfg(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = CFG_DW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk) exposure_i = 1'b1;
        @(negedge clk) exposure_i = 1'b0;
    endtask

    task automatic fot_len(output int n);
        n = 0;
        while (fot_o !== 1'b1) @(negedge clk);
        while (fot_o === 1'b1) begin n++; @(negedge clk); end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset fot_o", int'(fot_o), 0);
        chk("R1", "reset rot_o", int'(rot_o), 0);
        chk("R1", "reset read_o", int'(read_o), 0);
        chk("R1", "reset row_o", int'(row_o), 0);
        chk("R1", "reset kernel_o", int'(kernel_o), 0);
        chk("R1", "reset overrun_o", int'(overrun_o), 0);

        // band rows 2..4, row overhead 0xE1 keeps only N=1, column start 24 -> kernel 48
        wcfg(0, 2); wcfg(1, 4); wcfg(2, 'hE1); wcfg(3, 2); wcfg(4, 3); wcfg(5, 24);
        wcfg(7, 5);
        seq_rst_n = 1'b1;
        pulse();
        fot_len(n);
        chk("R2", "frame overhead cycles", n, 40);
        repeat (200) @(negedge clk);

        // edge during frame overhead, write while running, pending edge in readout
        frames = 0;
        pulse();
        repeat (8) @(negedge clk);
        pulse();
        repeat (2) @(negedge clk);
        chk("R7", "overrun after edge in FOT", int'(overrun_o), 1);
        wcfg(3, 0);
        repeat (55) @(negedge clk);
        chk("R5", "in kernel readout", int'(read_o), 1);
        pulse();
        fot_len(n);
        chk("R9", "running write ignored, FOT cycles", n, 40);
        repeat (200) @(negedge clk);
        chk("R8", "frames from pending edge", frames, 2);

        // sequencer hold clears overrun; clamp column, single row, no sample
        seq_rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "overrun cleared by hold", int'(overrun_o), 0);
        wcfg(4, 0); wcfg(5, 30); wcfg(0, 5); wcfg(1, 3); wcfg(3, 0);
        seq_rst_n = 1'b1;
        pulse();
        fot_len(n);
        chk("R2", "frame overhead N=0 cycles", n, 8);
        repeat (40) @(negedge clk);
        chk("R6", "single row band row_o", int'(row_o), 5);
        chk("R5", "clamped last kernel", int'(kernel_o), NUM_KERNELS - 1);

        // sample longer than frame overhead
        seq_rst_n = 1'b0;
        wcfg(4, 200);
        seq_rst_n = 1'b1;
        pulse();
        repeat (40) @(negedge clk);

        // two edges in readout: one pending, second dropped
        seq_rst_n = 1'b0;
        wcfg(0, 0); wcfg(1, 3); wcfg(5, 0); wcfg(4, 1);
        seq_rst_n = 1'b1;
        frames = 0;
        pulse();
        repeat (100) @(negedge clk);
        pulse();
        repeat (5) @(negedge clk);
        pulse();
        repeat (2) @(negedge clk);
        chk("R8", "overrun after second pending edge", int'(overrun_o), 1);
        repeat (2000) @(negedge clk);
        chk("R8", "frames with one pending", frames, 2);
        chk("R6", "idle after last row", int'(read_o || rot_o || fot_o), 0);

        // defaults after full reset
        rst = 1'b1;
        seq_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "overrun after reset", int'(overrun_o), 0);
        wcfg(1, 1);
        seq_rst_n = 1'b1;
        pulse();
        fot_len(n);
        chk("R1", "default frame overhead cycles", n, 648);
        repeat (600) @(negedge clk);
        chk("R6", "default band last row", int'(row_o), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule